// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the 32-bit control and status word of a floating-point unit attached to a RISC core. Software reads and writes the whole word through a register-bus port. The floating-point datapath uses a separate side port. On it the datapath reports the exception bits of each completed operation, and it writes single compare condition codes. The block also drives the stored rounding mode to the datapath, a packed 8-bit condition-code vector to the branch logic, and a trap request whenever an exception is pending and allowed to trap.

The exception status comes in three fields. The cause field holds the result of the most recent operation only. The flags field accumulates exceptions until software clears it. The enable field selects which exceptions raise a trap. The eight condition codes are not adjacent in the word: code 0 stands alone at bit 23, and codes 1 to 7 occupy bits 25 to 31. The block gathers them into one contiguous vector. Reserved bits always read as zero.

Top module: `fpcsr_unit`

## Requirements
- R1: A synchronous active-high reset clears the whole word to 0x00000000, so the packed condition vector, the rounding mode and the trap request all read zero.
- R2: A bus write stores the written data into bits 31:25, 23 and 17:0 (write mask 0xFE83FFFF); bits 24 and 22:18 always read as zero. The read port shows the new value in the cycle after the write edge.
- R3: The rounding-mode output always equals bits 1:0 of the word.
- R4: Condition code 0 is stored at bit 23 and code n (1 to 7) at bit n+24; packed-vector bit n carries code n.
- R5: A condition-code operation (strobe, 3-bit code number, value) writes only the selected code's bit and leaves every other bit of the word unchanged.
- R6: An exception report replaces the cause field (bits 17:12) with the reported 6 bits. The bit encoding is inexact=bit 0, underflow=bit 1, overflow=bit 2, divide-by-zero=bit 3, invalid=bit 4, unimplemented=bit 5.
- R7: An exception report ORs its low 5 bits into the flags field (bits 6:2); flags clear only through a bus write or reset.
- R8: The trap request is high exactly when the bitwise AND of cause[4:0] and enable (bits 11:7) is nonzero, or when cause bit 5 (unimplemented) is set. It follows the stored word, so it responds in the cycle after any update.
- R9: When a bus write coincides with an exception report or a condition-code operation, the bus write alone determines the new word.
- R10: An exception report and a condition-code operation in the same cycle without a bus write both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register-bus write strobe |
| bus_wr_data | input | 32 | Register-bus write data |
| bus_rd_data | output | 32 | Current register word |
| dp_exc_vld | input | 1 | Datapath exception report strobe |
| dp_exc_bits | input | 6 | Reported exception bits |
| dp_cc_we | input | 1 | Condition-code write strobe |
| dp_cc_num | input | 3 | Condition-code number 0 to 7 |
| dp_cc_val | input | 1 | Value written to the selected code |
| cc_vec | output | 8 | Packed condition codes, code n at bit n |
| round_mode | output | 2 | Stored rounding mode |
| trap_req | output | 1 | Enabled exception pending |

## Verification
Every output is derived combinationally from the single stored word. A wrong internal bit therefore shows up at the read port within one cycle of the update that caused it. A misplaced condition code shows as a mismatch between the read word and the packed vector. A cause or flag update that goes to the wrong place shows through a wrong trap request for some combination of cause and enable. For that reason the bench sweeps every cause value against every enable value, and sets and clears every condition code from both the all-clear and the all-set state.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

    localparam int CSR_W      = 32;
    localparam int CC_NUM     = 8;
    localparam int CC_IDX_W   = $clog2(CC_NUM);
    localparam int CC0_POS    = 23;
    localparam int CCHI_BASE  = 24;
    localparam int EXC_W      = 5;
    localparam int CAUSE_W    = EXC_W + 1;
    localparam int RM_W       = 2;

    // exception bit indices inside cause / flags / enable
    localparam int EXC_INEXACT  = 0;
    localparam int EXC_UNDERFL  = 1;
    localparam int EXC_OVERFL   = 2;
    localparam int EXC_DIVZERO  = 3;
    localparam int EXC_INVALID  = 4;
    localparam int EXC_UNIMPL   = 5;

    // writable bits: codes 1..7, code 0, cause, enable, flags, rounding
    localparam logic [CSR_W-1:0] WR_MASK = 32'hFE83_FFFF;

    typedef struct packed {
        logic [CC_NUM-2:0]  cc_hi;    // codes 1..7, bits 31:25
        logic               rsv_a;    // bit 24
        logic               cc_zero;  // bit 23
        logic [4:0]         rsv_b;    // bits 22:18
        logic [CAUSE_W-1:0] cause;    // bits 17:12
        logic [EXC_W-1:0]   enable;   // bits 11:7
        logic [EXC_W-1:0]   flags;    // bits 6:2
        logic [RM_W-1:0]    rmode;    // bits 1:0
    } csr_view_t;

    function automatic int cc_bit_pos(input int n);
        return (n == 0) ? CC0_POS : (n + CCHI_BASE);
    endfunction

endpackage

// File: rtl/fpcsr_regfile.sv
module fpcsr_regfile
    import fpcsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr_en,
    input  logic [CSR_W-1:0]    bus_wr_data,
    input  logic                dp_exc_vld,
    input  logic [CAUSE_W-1:0]  dp_exc_bits,
    input  logic                dp_cc_we,
    input  logic [CC_IDX_W-1:0] dp_cc_num,
    input  logic                dp_cc_val,
    output csr_view_t           csr_q
);

    csr_view_t         after_exc;
    logic [CSR_W-1:0]  after_cc;
    logic [CSR_W-1:0]  nxt;

    // exception report: cause replaced, flags accumulated
    always_comb begin
        after_exc = csr_q;
        if (dp_exc_vld) begin
            after_exc.cause = dp_exc_bits;
            after_exc.flags = csr_q.flags | dp_exc_bits[EXC_W-1:0];
        end
    end

    // condition-code write to a single scattered bit
    always_comb begin
        after_cc = after_exc;
        if (dp_cc_we) begin
            for (int n = 0; n < CC_NUM; n++) begin
                if (dp_cc_num == CC_IDX_W'(n))
                    after_cc[cc_bit_pos(n)] = dp_cc_val;
            end
        end
    end

    // bus write has the last word
    always_comb begin
        nxt = after_cc;
        if (bus_wr_en)
            nxt = bus_wr_data & WR_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst)
            csr_q <= '0;
        else
            csr_q <= csr_view_t'(nxt);
    end

endmodule

// File: rtl/fpcsr_cc_pack.sv
module fpcsr_cc_pack
    import fpcsr_pkg::*;
(
    input  csr_view_t          csr,
    output logic [CC_NUM-1:0]  cc_vec
);

    logic [CSR_W-1:0] word;
    assign word = csr;

    for (genvar g = 0; g < CC_NUM; g++) begin : g_gather
        assign cc_vec[g] = word[cc_bit_pos(g)];
    end

endmodule

// File: rtl/fpcsr_trap_eval.sv
module fpcsr_trap_eval
    import fpcsr_pkg::*;
(
    input  logic [CAUSE_W-1:0] cause,
    input  logic [EXC_W-1:0]   enable,
    output logic               trap
);

    logic masked_hit;

    assign masked_hit = |(cause[EXC_W-1:0] & enable);
    assign trap       = masked_hit | cause[EXC_UNIMPL];

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
    import fpcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr_en,
    input  logic [31:0] bus_wr_data,
    output logic [31:0] bus_rd_data,
    input  logic        dp_exc_vld,
    input  logic [5:0]  dp_exc_bits,
    input  logic        dp_cc_we,
    input  logic [2:0]  dp_cc_num,
    input  logic        dp_cc_val,
    output logic [7:0]  cc_vec,
    output logic [1:0]  round_mode,
    output logic        trap_req
);

    csr_view_t csr_q;

    fpcsr_regfile u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .dp_exc_vld  (dp_exc_vld),
        .dp_exc_bits (dp_exc_bits),
        .dp_cc_we    (dp_cc_we),
        .dp_cc_num   (dp_cc_num),
        .dp_cc_val   (dp_cc_val),
        .csr_q       (csr_q)
    );

    fpcsr_cc_pack u_pack (
        .csr    (csr_q),
        .cc_vec (cc_vec)
    );

    fpcsr_trap_eval u_trap (
        .cause  (csr_q.cause),
        .enable (csr_q.enable),
        .trap   (trap_req)
    );

    assign bus_rd_data = csr_q;
    assign round_mode  = csr_q.rmode;

endmodule

// File: rtl/fpcsr_chk.sv
module fpcsr_chk
    import fpcsr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_wr_en,
    input logic [31:0] bus_wr_data,
    input logic [31:0] bus_rd_data,
    input logic        dp_exc_vld,
    input logic [5:0]  dp_exc_bits,
    input logic        dp_cc_we,
    input logic [7:0]  cc_vec,
    input logic [1:0]  round_mode,
    input logic        trap_req
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (bus_rd_data == 32'h0));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_data & ~WR_MASK) == 32'h0);

    // R3
    round_out_chk: assert property (@(posedge clk) disable iff (rst)
        round_mode == bus_rd_data[1:0]);

    // R4
    cc_gather_chk: assert property (@(posedge clk) disable iff (rst)
        cc_vec == {bus_rd_data[31:25], bus_rd_data[23]});

    // R5
    cc_single_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_cc_we && !bus_wr_en) |=> ($countones(cc_vec ^ $past(cc_vec)) <= 1));

    // R6
    cause_load_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_exc_vld && !bus_wr_en) |=> (bus_rd_data[17:12] == $past(dp_exc_bits)));

    // R7
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_en |=> ((bus_rd_data[6:2] & $past(bus_rd_data[6:2])) == $past(bus_rd_data[6:2])));

    // R8
    trap_rule_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req == ((|(bus_rd_data[16:12] & bus_rd_data[11:7])) | bus_rd_data[17]));

    // R9
    bus_wins_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en |=> (bus_rd_data == ($past(bus_wr_data) & WR_MASK)));

endmodule

bind fpcsr_unit fpcsr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_data (bus_rd_data),
    .dp_exc_vld  (dp_exc_vld),
    .dp_exc_bits (dp_exc_bits),
    .dp_cc_we    (dp_cc_we),
    .cc_vec      (cc_vec),
    .round_mode  (round_mode),
    .trap_req    (trap_req)
);

// File: tb/fpcsr_unit_bench.sv
`timescale 1ns/1ps
module fpcsr_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic [31:0] bus_rd_data;
    logic        dp_exc_vld = 1'b0;
    logic [5:0]  dp_exc_bits = '0;
    logic        dp_cc_we = 1'b0;
    logic [2:0]  dp_cc_num = '0;
    logic        dp_cc_val = 1'b0;
    logic [7:0]  cc_vec;
    logic [1:0]  round_mode;
    logic        trap_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] exp_w = '0;

    localparam logic [31:0] MASK = 32'hFE83_FFFF;

    always #10 clk = ~clk;

    fpcsr_unit u_fpcsr_unit (
        .clk(clk), .rst(rst),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
        .dp_exc_vld(dp_exc_vld), .dp_exc_bits(dp_exc_bits),
        .dp_cc_we(dp_cc_we), .dp_cc_num(dp_cc_num), .dp_cc_val(dp_cc_val),
        .cc_vec(cc_vec), .round_mode(round_mode), .trap_req(trap_req)
    );

    function automatic int pos_of(input int n);
        return (n == 0) ? 23 : n + 24;
    endfunction

    function automatic logic [7:0] pack_of(input logic [31:0] w);
        logic [7:0] v;
        for (int n = 0; n < 8; n++) v[n] = w[pos_of(n)];
        return v;
    endfunction

    function automatic logic trap_of(input logic [31:0] w);
        int c, e;
        c = int'(w[17:12]);
        e = int'(w[11:7]);
        return ((c % 32) & e) != 0 || c >= 32;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "word",  bus_rd_data, exp_w);
        chk(req, "ccvec", {24'h0, cc_vec}, {24'h0, pack_of(exp_w)});
        chk(req, "rmode", {30'h0, round_mode}, {30'h0, exp_w[1:0]});
        chk(req, "trap",  {31'h0, trap_req}, {31'h0, trap_of(exp_w)});
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        bus_wr_en  = 1'b0;
        dp_exc_vld = 1'b0;
        dp_cc_we   = 1'b0;
        rst        = 1'b0;
    endtask

    task automatic bus_write(input logic [31:0] d);
        bus_wr_en = 1'b1; bus_wr_data = d;
        tick();
        exp_w = d & MASK;
    endtask

    task automatic exc_report(input logic [5:0] b);
        dp_exc_vld = 1'b1; dp_exc_bits = b;
        tick();
        exp_w[17:12] = b;
        exp_w[6:2]   = exp_w[6:2] | b[4:0];
    endtask

    task automatic cc_write(input int n, input logic v);
        dp_cc_we = 1'b1; dp_cc_num = 3'(n); dp_cc_val = v;
        tick();
        exp_w[pos_of(n)] = v;
    endtask

    initial begin
        tick();
        rst = 1'b1;
        tick();
        exp_w = '0;
        // R1 reset state
        chk_all("R1");

        // R2 write masking, reserved bits zero
        bus_write(32'hFFFF_FFFF); chk_all("R2");
        bus_write(32'h0147_C000); chk_all("R2");
        bus_write(32'hA5A5_5A5A); chk_all("R2");
        // R3 rounding mode values
        for (int r = 0; r < 4; r++) begin
            bus_write(32'h0000_0F00 | 32'(r));
            chk_all("R3");
        end

        // R4 set each code from all-clear
        bus_write(32'h0);
        for (int n = 0; n < 8; n++) begin
            cc_write(n, 1'b1);
            chk_all("R4");
            chk("R4", "prefix", {24'h0, cc_vec}, 32'((1 << (n + 1)) - 1));
        end
        // R5 clear each code from all-set, others untouched
        for (int n = 0; n < 8; n++) begin
            bus_write(32'hFE83_FFFF);
            cc_write(n, 1'b0);
            chk_all("R5");
            chk("R5", "onehole", {24'h0, cc_vec}, {24'h0, ~(8'(1) << n)});
        end
        // R5 set on a lone code from clear state leaves other fields alone
        bus_write(32'h0003_5A56);
        cc_write(5, 1'b1);
        chk_all("R5");

        // R6 / R8 full sweep of cause against enable
        for (int e = 0; e < 32; e++) begin
            bus_write(32'(e) << 7);
            for (int c = 0; c < 64; c++) begin
                exc_report(6'(c));
                chk_all("R8");
                chk("R6", "cause", {26'h0, bus_rd_data[17:12]}, 32'(c));
            end
        end
        // R7 flags accumulate and stay
        bus_write(32'h0);
        exc_report(6'b000001); chk_all("R7");
        exc_report(6'b000010); chk_all("R7");
        chk("R7", "flags", {27'h0, bus_rd_data[6:2]}, 32'h3);
        exc_report(6'b000000); chk_all("R7");
        chk("R7", "kept", {27'h0, bus_rd_data[6:2]}, 32'h3);
        exc_report(6'b100000); chk_all("R7");
        chk("R7", "unimpl", {27'h0, bus_rd_data[6:2]}, 32'h3);

        // R9 bus write against simultaneous datapath updates
        bus_write(32'h0000_0000);
        bus_wr_en = 1'b1; bus_wr_data = 32'h0280_1234;
        dp_exc_vld = 1'b1; dp_exc_bits = 6'h3F;
        dp_cc_we = 1'b1; dp_cc_num = 3'd7; dp_cc_val = 1'b1;
        tick();
        exp_w = 32'h0280_1234 & MASK;
        chk_all("R9");

        // R10 exception report and code write together
        bus_write(32'h0000_0400);
        dp_exc_vld = 1'b1; dp_exc_bits = 6'h08;
        dp_cc_we = 1'b1; dp_cc_num = 3'd0; dp_cc_val = 1'b1;
        tick();
        exp_w[17:12] = 6'h08;
        exp_w[6:2]   = exp_w[6:2] | 5'h08;
        exp_w[23]    = 1'b1;
        chk_all("R10");

        // R1 reset in mid-run
        bus_write(32'hFFFF_FFFF);
        rst = 1'b1;
        tick();
        exp_w = '0;
        chk_all("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule